// File: doc/BRIEF.md
# Leakage-Cancel Auto-Zero Controller

Before a bank of test transistors is measured, every device in the bank is switched off. The parasitic current that remains on the measurement node is then cancelled by one of two current DACs: one pushes current into the node and the other pulls current out of it. This controller makes a first converter reading with both DACs off, and the sign of that reading selects the DAC. It drives the chosen DAC fully on and then refines that DAC's 8-bit code by a successive-approximation search from MSB to LSB. The code is expanded into a thermometer control word for the selected DAC, while the other DAC is held at zero.

When the search ends, the code is held. The residual reading at the final code is stored as an offset, and every later device reading is returned with that offset already subtracted. A new auto-zero starts after reset and whenever the bank address or the gate-bias index changes. Device-measurement requests are not granted while a run is in progress or pending.

The converter is driven through a start pulse, a done strobe and a signed result.

Top module: `leak_autozero`

## Requirements
- R1: While reset is held, busy, both thermometer words, the offset, meas_gnt and res_valid are all zero. The first cycle after reset starts an auto-zero run.
- R2: A run starts only after reset or when bank_addr or bias_idx differs from the values captured at the start of the last run. Device-measurement requests never start one. A change that arrives during a run starts a second run right after the first ends. adc_start is only ever high while busy.
- R3: The first conversion of a run is taken with both DACs off. If that reading is exactly zero, the run ends with both DACs at code 0 and an offset of 0.
- R4: A positive reading (current into the node) selects the sink DAC. A negative reading selects the source DAC. At no time are both thermometer words nonzero.
- R5: The second conversion of a run with nonzero leakage is taken with the selected DAC at code 255. If the sign of that reading has not flipped (zero counts as not flipped), the run ends at code 255.
- R6: Otherwise eight further conversions test bits 7 down to 0. Each test sets the bit on top of the bits kept so far. The bit is kept when the reading has the same sign as the first reading or is zero, and it is cleared when the sign flips. The final code is the largest code whose reading does not flip sign.
- R7: The stored offset is the reading at the final code, or the first reading when the final code is 0.
- R8: A DAC's thermometer word has lines 0 through code-1 high and all others low.
- R9: busy is high for the whole run. meas_gnt equals meas_req only when not busy and no run is pending; otherwise it is low.
- R10: One cycle after an adc_done while idle, res_valid is high and res_val equals adc_val minus the stored offset, computed one bit wider.
- R11: Between runs, both thermometer words and the offset remain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_addr | input | BANK_W | Address of the bank under test |
| bias_idx | input | BIAS_W | Index of the gate-bias setting |
| meas_req | input | 1 | Request to measure a device |
| meas_gnt | output | 1 | Device measurement may proceed |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_done | input | 1 | Conversion result valid strobe |
| adc_val | input | ADC_W | Signed converter result; positive means current into the node |
| busy | output | 1 | Auto-zero run in progress |
| src_therm | output | 2**CODE_W-1 | Thermometer control word of the source DAC |
| snk_therm | output | 2**CODE_W-1 | Thermometer control word of the sink DAC |
| az_offset | output | ADC_W | Stored residual reading |
| res_valid | output | 1 | Corrected device reading valid |
| res_val | output | ADC_W+1 | Device reading minus stored offset |

## Verification
The hardest case to reach is a bank change that arrives in the middle of a run. The controller has to finish the run that is already in progress, holding the captured address, and then start a second run on its own without granting any device request in between. The bench reaches this case by moving bank_addr twice, a few cycles after busy rises. It expects two complete results from the scoreboard and polls meas_gnt through both runs. The search boundaries come from a converter model in which each DAC step is worth three result units. Leakage values of 0, ±1, ±2, exactly full scale and beyond full scale exercise the zero exit, the all-bits-cleared end, the full-scale exit and residual offsets.

// File: rtl/az_pkg.sv
package az_pkg;

    typedef enum logic [1:0] {
        DAC_NONE = 2'd0,
        DAC_SRC  = 2'd1,
        DAC_SNK  = 2'd2
    } dac_sel_e;

    typedef enum logic [1:0] {
        PH_BASE = 2'd0,
        PH_FULL = 2'd1,
        PH_BIT  = 2'd2
    } phase_e;

    // A reading flipped when its sign is opposite to the original leakage.
    function automatic logic sign_flipped(input logic leak_neg,
                                          input logic rd_pos,
                                          input logic rd_neg);
        return leak_neg ? rd_pos : rd_neg;
    endfunction

endpackage

// File: rtl/az_change_det.sv
module az_change_det #(
    parameter int BANK_W = 10,
    parameter int BIAS_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] bank_addr,
    input  logic [BIAS_W-1:0] bias_idx,
    input  logic              capture,
    output logic              chg
);
    logic [BANK_W-1:0] bank_q;
    logic [BIAS_W-1:0] bias_q;
    logic              fresh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q  <= '0;
            bias_q  <= '0;
            fresh_q <= 1'b1;
        end else if (capture) begin
            bank_q  <= bank_addr;
            bias_q  <= bias_idx;
            fresh_q <= 1'b0;
        end
    end

    assign chg = fresh_q || (bank_addr != bank_q) || (bias_idx != bias_q);
endmodule

// File: rtl/az_search.sv
module az_search
    import az_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int ADC_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chg,
    input  logic              adc_done,
    input  logic [ADC_W-1:0]  adc_val,
    output logic              busy,
    output logic              capture,
    output logic              adc_start,
    output dac_sel_e          dac_sel,
    output logic [CODE_W-1:0] code,
    output logic [ADC_W-1:0]  offset
);
    localparam int BIT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam logic [CODE_W-1:0] FULL  = {CODE_W{1'b1}};
    localparam logic [BIT_W-1:0]  TOP_B = BIT_W'(CODE_W - 1);

    phase_e            ph_q;
    logic [BIT_W-1:0]  bit_q;
    logic [CODE_W-1:0] kept_q;
    logic              neg_q;

    logic              rd_pos, rd_neg, flip;
    logic [CODE_W-1:0] kept_nx;
    logic [BIT_W-1:0]  bit_dn;

    assign rd_neg  = adc_val[ADC_W-1];
    assign rd_pos  = !adc_val[ADC_W-1] && (adc_val != '0);
    assign flip    = sign_flipped(neg_q, rd_pos, rd_neg);
    assign kept_nx = flip ? kept_q : (kept_q | (CODE_W'(1) << bit_q));
    assign bit_dn  = bit_q - BIT_W'(1);
    assign capture = !busy && chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            ph_q      <= PH_BASE;
            bit_q     <= '0;
            kept_q    <= '0;
            neg_q     <= 1'b0;
            dac_sel   <= DAC_NONE;
            code      <= '0;
            offset    <= '0;
            adc_start <= 1'b0;
        end else begin
            adc_start <= 1'b0;
            if (!busy) begin
                if (chg) begin
                    busy      <= 1'b1;
                    ph_q      <= PH_BASE;
                    dac_sel   <= DAC_NONE;
                    code      <= '0;
                    adc_start <= 1'b1;
                end
            end else if (adc_done) begin
                unique case (ph_q)
                    PH_BASE: begin
                        offset <= adc_val;
                        if (adc_val == '0) begin
                            busy <= 1'b0;
                        end else begin
                            neg_q     <= rd_neg;
                            dac_sel   <= rd_neg ? DAC_SRC : DAC_SNK;
                            code      <= FULL;
                            ph_q      <= PH_FULL;
                            adc_start <= 1'b1;
                        end
                    end
                    PH_FULL: begin
                        if (!flip) begin
                            offset <= adc_val;
                            busy   <= 1'b0;
                        end else begin
                            kept_q    <= '0;
                            bit_q     <= TOP_B;
                            code      <= CODE_W'(1) << TOP_B;
                            ph_q      <= PH_BIT;
                            adc_start <= 1'b1;
                        end
                    end
                    default: begin
                        kept_q <= kept_nx;
                        if (!flip) offset <= adc_val;
                        if (bit_q == '0) begin
                            code <= kept_nx;
                            busy <= 1'b0;
                        end else begin
                            code      <= kept_nx | (CODE_W'(1) << bit_dn);
                            bit_q     <= bit_dn;
                            adc_start <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/az_therm.sv
module az_therm #(
    parameter int CODE_W = 8
) (
    input  logic                  en,
    input  logic [CODE_W-1:0]     code,
    output logic [2**CODE_W-2:0]  therm
);
    localparam int LINES = 2**CODE_W - 1;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign therm[i] = en && (32'(code) > i);
    end
endmodule

// File: rtl/az_offset_sub.sv
module az_offset_sub #(
    parameter int ADC_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [ADC_W-1:0] adc_val,
    input  logic [ADC_W-1:0] offset,
    output logic             res_valid,
    output logic [ADC_W:0]   res_val
);
    logic [ADC_W:0] diff;

    assign diff = {adc_val[ADC_W-1], adc_val} - {offset[ADC_W-1], offset};

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_val   <= '0;
        end else begin
            res_valid <= take;
            if (take) res_val <= diff;
        end
    end
endmodule

// File: rtl/leak_autozero.sv
module leak_autozero
    import az_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int ADC_W  = 12,
    parameter int BANK_W = 10,
    parameter int BIAS_W = 4,
    localparam int THERM_W = 2**CODE_W - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [BANK_W-1:0]  bank_addr,
    input  logic [BIAS_W-1:0]  bias_idx,
    input  logic               meas_req,
    output logic               meas_gnt,
    output logic               adc_start,
    input  logic               adc_done,
    input  logic [ADC_W-1:0]   adc_val,
    output logic               busy,
    output logic [THERM_W-1:0] src_therm,
    output logic [THERM_W-1:0] snk_therm,
    output logic [ADC_W-1:0]   az_offset,
    output logic               res_valid,
    output logic [ADC_W:0]     res_val
);
    logic              chg, capture;
    dac_sel_e          dac_sel;
    logic [CODE_W-1:0] code;
    logic [THERM_W-1:0] therm_w [2];

    az_change_det #(.BANK_W(BANK_W), .BIAS_W(BIAS_W)) u_chg (
        .clk(clk), .rst(rst), .bank_addr(bank_addr), .bias_idx(bias_idx),
        .capture(capture), .chg(chg)
    );

    az_search #(.CODE_W(CODE_W), .ADC_W(ADC_W)) u_search (
        .clk(clk), .rst(rst), .chg(chg), .adc_done(adc_done), .adc_val(adc_val),
        .busy(busy), .capture(capture), .adc_start(adc_start),
        .dac_sel(dac_sel), .code(code), .offset(az_offset)
    );

    for (genvar k = 0; k < 2; k++) begin : g_dac
        localparam dac_sel_e MINE = (k == 0) ? DAC_SRC : DAC_SNK;
        az_therm #(.CODE_W(CODE_W)) u_therm (
            .en(dac_sel == MINE), .code(code), .therm(therm_w[k])
        );
    end

    assign src_therm = therm_w[0];
    assign snk_therm = therm_w[1];

    az_offset_sub #(.ADC_W(ADC_W)) u_sub (
        .clk(clk), .rst(rst), .take(adc_done && !busy), .adc_val(adc_val),
        .offset(az_offset), .res_valid(res_valid), .res_val(res_val)
    );

    assign meas_gnt = meas_req && !busy && !chg;
endmodule

// File: rtl/leak_autozero_chk.sv
module leak_autozero_chk #(
    parameter int THERM_W = 255,
    parameter int ADC_W   = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               meas_gnt,
    input logic               adc_start,
    input logic [THERM_W-1:0] src_therm,
    input logic [THERM_W-1:0] snk_therm,
    input logic [ADC_W-1:0]   az_offset
);
    p_one_dac_r4: assert property (@(posedge clk) disable iff (rst)
        !((|src_therm) && (|snk_therm)));

    p_therm_form_r8: assert property (@(posedge clk) disable iff (rst)
        (((src_therm + THERM_W'(1)) & src_therm) == '0) &&
        (((snk_therm + THERM_W'(1)) & snk_therm) == '0));

    p_no_gnt_busy_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !meas_gnt);

    p_start_in_run_r2: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> busy);

    p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |->
            ($stable(src_therm) && $stable(snk_therm) && $stable(az_offset)));
endmodule

bind leak_autozero leak_autozero_chk #(.THERM_W(THERM_W), .ADC_W(ADC_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .meas_gnt(meas_gnt), .adc_start(adc_start),
    .src_therm(src_therm), .snk_therm(snk_therm), .az_offset(az_offset)
);

// File: tb/leak_autozero_test.sv
module leak_autozero_test;
    localparam int CODE_W  = 8;
    localparam int ADC_W   = 12;
    localparam int BANK_W  = 10;
    localparam int BIAS_W  = 4;
    localparam int THERM_W = 2**CODE_W - 1;
    localparam int STEP    = 3;

    typedef struct {
        int code;
        int dac;   // 0 none, 1 source, 2 sink
        int off;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [BANK_W-1:0]  bank_addr = '0;
    logic [BIAS_W-1:0]  bias_idx = '0;
    logic               meas_req = 1'b0;
    logic               meas_gnt, adc_start, busy, res_valid;
    logic               adc_done;
    logic [ADC_W-1:0]   adc_val;
    logic [THERM_W-1:0] src_therm, snk_therm;
    logic [ADC_W-1:0]   az_offset;
    logic [ADC_W:0]     res_val;

    leak_autozero #(.CODE_W(CODE_W), .ADC_W(ADC_W), .BANK_W(BANK_W), .BIAS_W(BIAS_W)) uut (
        .clk(clk), .rst(rst), .bank_addr(bank_addr), .bias_idx(bias_idx),
        .meas_req(meas_req), .meas_gnt(meas_gnt), .adc_start(adc_start),
        .adc_done(adc_done), .adc_val(adc_val), .busy(busy),
        .src_therm(src_therm), .snk_therm(snk_therm), .az_offset(az_offset),
        .res_valid(res_valid), .res_val(res_val)
    );

    always #10 clk = ~clk;

    int   n_cmp = 0, n_bad = 0;
    exp_t q[$];
    int   leak = 0;
    int   dev_val = 0, dev_req = 0, dev_ack = 0;
    int   conv_idx = 0, full_seen = 0;
    int   last_off = 0;
    bit   done_all = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [THERM_W-1:0] therm_of(input int c);
        logic [THERM_W-1:0] v;
        for (int i = 0; i < THERM_W; i++) v[i] = (i < c);
        return v;
    endfunction

    function automatic exp_t predict(input int l);
        exp_t e;
        int   mag;
        mag    = (l < 0) ? -l : l;
        e.code = (mag / STEP > 255) ? 255 : mag / STEP;
        e.dac  = (l > 0) ? 2 : (l < 0) ? 1 : 0;
        if (l == 0) e.code = 0;
        e.off  = (l > 0) ? l - STEP * e.code : (l < 0) ? l + STEP * e.code : 0;
        return e;
    endfunction

    // Converter model: three cycles per conversion.
    initial begin
        int cnt;
        cnt = 0;
        adc_done = 1'b0;
        adc_val  = '0;
        forever begin
            @(negedge clk);
            adc_done = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    int rd;
                    conv_idx++;
                    rd = leak + STEP * $countones(src_therm) - STEP * $countones(snk_therm);
                    if (conv_idx == 2) full_seen = $countones(src_therm) + $countones(snk_therm);
                    adc_done = 1'b1;
                    adc_val  = ADC_W'(rd);
                end
            end else if (dev_req != dev_ack) begin
                dev_ack++;
                adc_done = 1'b1;
                adc_val  = ADC_W'(dev_val);
            end
            if (adc_start) cnt = 3;
        end
    end

    // Monitor: on each end of run, pop and compare.
    initial begin
        logic busy_prev;
        busy_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && busy && !busy_prev) conv_idx = 0;
            if (!rst && busy_prev && !busy) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2 unexpected run", 1, 0);
                end else begin
                    exp_t e;
                    logic [THERM_W-1:0] xs, xk;
                    e  = q.pop_front();
                    xs = (e.dac == 1) ? therm_of(e.code) : '0;
                    xk = (e.dac == 2) ? therm_of(e.code) : '0;
                    check(src_therm == xs, "R4/R6/R8 source word ones", $countones(src_therm), $countones(xs));
                    check(snk_therm == xk, "R4/R6/R8 sink word ones", $countones(snk_therm), $countones(xk));
                    check($signed(az_offset) == e.off, "R7 offset", $signed(az_offset), e.off);
                    if (e.dac != 0)
                        check(full_seen == 255, "R5 full scale on second conversion", full_seen, 255);
                    else
                        check(conv_idx == 1, "R3 single conversion on zero", conv_idx, 1);
                end
            end
            busy_prev = busy;
        end
    end

    task automatic wait_idle();
        int t;
        t = 0;
        while ((q.size() != 0 || busy) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(t < 2000, "R9 run completes", t, 0);
    endtask

    task automatic run_bank(input int l);
        @(negedge clk);
        leak = l;
        q.push_back(predict(l));
        last_off = predict(l).off;
        bank_addr = bank_addr + 1'b1;
        wait_idle();
    endtask

    task automatic run_bias(input int l);
        @(negedge clk);
        leak = l;
        q.push_back(predict(l));
        last_off = predict(l).off;
        bias_idx = bias_idx + 1'b1;
        wait_idle();
    endtask

    task automatic measure(input int v, input string tag);
        int t;
        @(negedge clk);
        meas_req = 1'b1;
        t = 0;
        while (!meas_gnt && t < 2000) begin
            @(negedge clk);
            t++;
        end
        meas_req = 1'b0;
        dev_val = v;
        dev_req++;
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!res_valid && t < 20);
        check(res_valid && $signed(res_val) == v - last_off, tag, $signed(res_val), v - last_off);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_all) begin
            check(1'b0, "watchdog", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        meas_req = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && src_therm == '0 && snk_therm == '0, "R1 reset outputs", int'(busy), 0);
        check(az_offset == '0 && !meas_gnt && !res_valid, "R1 reset offset/grant", $signed(az_offset), 0);
        meas_req = 1'b0;
        leak = 100;
        q.push_back(predict(100));
        last_off = predict(100).off;
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R1 run starts after reset", int'(busy), 1);
        wait_idle();

        run_bias(-50);      // R4 source selection
        run_bank(0);        // R3 zero exit
        run_bank(1);        // R6 all bits cleared, sink selected
        run_bank(-2);       // R6/R7 below one step
        run_bank(2000);     // R5 beyond full scale
        run_bias(-2000);
        run_bank(765);      // R5 exactly full scale, zero residual
        run_bank(300);

        // R10 and R2: device readings without any address change
        measure(40, "R10 corrected reading");
        measure(-7, "R10 corrected negative reading");
        begin
            bit stayed;
            stayed = 1'b1;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (busy) stayed = 1'b0;
            end
            check(stayed, "R2 no run from device measurements", int'(!stayed), 0);
        end

        // R2: bank changes twice during a run
        @(negedge clk);
        leak = 77;
        q.push_back(predict(77));
        q.push_back(predict(77));
        last_off = predict(77).off;
        bank_addr = bank_addr + 1'b1;
        meas_req = 1'b1;
        repeat (5) @(negedge clk);
        bank_addr = bank_addr + 1'b1;
        begin
            bit no_gnt;
            int t;
            no_gnt = 1'b1;
            t = 0;
            while ((q.size() != 0 || busy) && t < 2000) begin
                if (meas_gnt) no_gnt = 1'b0;
                @(negedge clk);
                t++;
            end
            check(no_gnt, "R9 no grant during back-to-back runs", int'(!no_gnt), 0);
            check(q.size() == 0, "R2 second run after mid-run change", q.size(), 0);
            check(meas_gnt == 1'b1, "R9 grant once idle", int'(meas_gnt), 1);
        end
        meas_req = 1'b0;

        // R9 hold-off: request together with a bias change
        @(negedge clk);
        leak = -31;
        q.push_back(predict(-31));
        last_off = predict(-31).off;
        bias_idx = bias_idx + 1'b1;
        meas_req = 1'b1;
        check(meas_gnt == 1'b0, "R9 pending change blocks grant", int'(meas_gnt), 0);
        wait_idle();
        meas_req = 1'b0;
        measure(500, "R10 reading after hold-off");

        // R11: outputs stay put across idle cycles
        begin
            logic [THERM_W-1:0] s0;
            logic [ADC_W-1:0]   o0;
            s0 = src_therm;
            o0 = az_offset;
            repeat (20) @(negedge clk);
            check(src_therm == s0 && az_offset == o0 && snk_therm == '0,
                  "R11 held between runs", $signed(az_offset), $signed(o0));
        end

        done_all = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule